// File: doc/BRIEF.md
# DMA coherent-access request converter

This block sits where DMA traffic enters an I/O bridge. It accepts one DMA request at a time over a valid/ready port. Each request carries an address, a read/write flag, one byte enable per byte of a 32-byte line, and a full line of write data. The block turns the request into one or two system-bus transactions and then reports completion on a response port.

The line address of each request is compared against a main-memory window, given by a base input and a size input. Software sets both before traffic starts. Requests that land inside the window become coherent line transactions. A write that does not cover the whole line is done in three steps: the line is read with exclusive ownership, the requested bytes are merged into it, and the merged line is written back. Requests outside the window become uncached transactions that keep the requester's byte enables, so a partial write outside memory never causes a read.

Top module: `dma_coh_conv`

## Requirements
- R1: A request targets memory when its line address (the address with its five low bits cleared) is at least `cfg_mem_base` and less than `cfg_mem_base + cfg_mem_size`. The line just below the base and the line at base plus size are both outside memory.
- R2: A read to memory issues one transaction with `bus_cmd` = 0 (coherent line read), the line address, and all 32 byte enables set.
- R3: A write to memory with all 32 byte enables set issues exactly one transaction, with `bus_cmd` = 2 (coherent line write), all byte enables set and the request data, and no read before it.
- R4: A write to memory with any byte enable clear first issues `bus_cmd` = 1 (read exclusive) with all byte enables set. It then issues `bus_cmd` = 2 with all byte enables set. In that write, byte i (data bits 8i+7..8i) is the request byte where enable bit i is set and the returned line byte where it is clear.
- R5: A read outside memory issues one transaction with `bus_cmd` = 3 (uncached read), the line address, and the request's byte enables unchanged.
- R6: A write outside memory issues exactly one transaction with `bus_cmd` = 4 (uncached write), the request's byte enables unchanged and the request data, even when the enables are partial.
- R7: The response of a read carries the returned line with every byte whose enable is clear forced to zero. The response of a write carries all-zero data. `rsp_write` repeats the request's direction.
- R8: Only one request is in flight. `req_ready` drops in the cycle after a request is accepted, stays low through any read-modify-write, and rises in the cycle after the response.
- R9: While `bus_valid` is high and `bus_ready` is low, the bus command, address, byte enables and data hold their values.
- R10: `rsp_valid` is high for exactly one cycle per accepted request, and no bus request is pending in that cycle.
- R11: After reset `req_ready` is high and `bus_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mem_base | input | 32 | Start of the main-memory window |
| cfg_mem_size | input | 32 | Size of the main-memory window in bytes |
| req_valid | input | 1 | DMA request present |
| req_ready | output | 1 | DMA request accepted when high with valid |
| req_addr | input | 32 | DMA request address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_be | input | 32 | Byte enables, bit i for byte i of the line |
| req_wdata | input | 256 | Write data, byte i in bits 8i+7..8i |
| bus_valid | output | 1 | System-bus transaction present |
| bus_ready | input | 1 | System bus takes the transaction |
| bus_cmd | output | 3 | 0 coherent read, 1 read exclusive, 2 coherent write, 3 uncached read, 4 uncached write |
| bus_addr | output | 32 | Line-aligned transaction address |
| bus_be | output | 32 | Transaction byte enables |
| bus_wdata | output | 256 | Transaction write data |
| bus_rvalid | input | 1 | Read data returned |
| bus_rdata | input | 256 | Returned line |
| rsp_valid | output | 1 | Completion pulse |
| rsp_write | output | 1 | Direction of the completed request |
| rsp_rdata | output | 256 | Read data with unrequested bytes zeroed |

## Verification
The bench targets the edges of the memory window: the base line, the last line inside, the line at base plus size, and the line below the base. A comparator that is off by one would send one of these with the wrong class of command. It drives partial writes on both sides of the window. A design that merged outside memory would emit an extra read, and one that skipped the merge inside memory would write stale or unmerged bytes. It also checks that full-line writes to memory never read first, and that read responses zero the bytes that were not asked for. Random stalls on `bus_ready` expose a request that changes before the bus takes it.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  typedef enum logic [2:0] {
    CMD_COH_RD  = 3'd0,
    CMD_COH_RDX = 3'd1,
    CMD_COH_WR  = 3'd2,
    CMD_UC_RD   = 3'd3,
    CMD_UC_WR   = 3'd4
  } bus_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_WR_REQ  = 3'd3,
    ST_RESP    = 3'd4
  } ctrl_state_e;

endpackage

// File: rtl/dcc_range_chk.sv
module dcc_range_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] win_size,
  output logic              in_mem
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((1 << OFF_W) - 1);

  logic [ADDR_W-1:0] line_addr;
  logic [ADDR_W-1:0] delta;
  logic              above_base;

  always_comb begin
    line_addr  = addr & ~OFF_MASK;
    above_base = (line_addr >= win_base);
    delta      = line_addr - win_base;
    in_mem     = above_base && (delta < win_size);
  end

endmodule

// File: rtl/dcc_merge.sv
module dcc_merge #(
  parameter int LINE_BYTES = 32
) (
  input  logic [LINE_BYTES*8-1:0] new_data,
  input  logic [LINE_BYTES*8-1:0] old_data,
  input  logic [LINE_BYTES-1:0]   byte_sel,
  output logic [LINE_BYTES*8-1:0] merged
);
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    assign merged[8*b +: 8] = byte_sel[b] ? new_data[8*b +: 8] : old_data[8*b +: 8];
  end
endmodule

// File: rtl/dcc_ctrl.sv
module dcc_ctrl
  import dcc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_write,
  input  logic [LINE_BYTES-1:0]   req_be,
  input  logic [LINE_BYTES*8-1:0] req_wdata,
  input  logic                    req_in_mem,
  output logic                    bus_valid,
  input  logic                    bus_ready,
  output logic [2:0]              bus_cmd,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [LINE_BYTES-1:0]   bus_be,
  output logic [LINE_BYTES*8-1:0] bus_wdata,
  input  logic                    bus_rvalid,
  input  logic [LINE_BYTES*8-1:0] bus_rdata,
  output logic                    rsp_valid,
  output logic                    rsp_write,
  output logic [LINE_BYTES*8-1:0] rsp_rdata
);
  localparam int DATA_W = LINE_BYTES * 8;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((1 << OFF_W) - 1);
  localparam logic [LINE_BYTES-1:0] ALL_BE = {LINE_BYTES{1'b1}};

  ctrl_state_e state_q, state_d;
  logic [ADDR_W-1:0]     addr_q;
  logic [LINE_BYTES-1:0] be_q;
  logic [DATA_W-1:0]     wdata_q, wdata_d;
  logic [DATA_W-1:0]     rdata_q, rdata_d;
  logic                  wr_q, mem_q;

  logic accept, full_line, rd_done;
  logic cap_en, wdata_en, rdata_en;
  logic [DATA_W-1:0] merged_line, masked_line;
  bus_cmd_e cmd_e;

  dcc_merge #(.LINE_BYTES(LINE_BYTES)) u_rmw_merge (
    .new_data (wdata_q),
    .old_data (bus_rdata),
    .byte_sel (be_q),
    .merged   (merged_line)
  );

  dcc_merge #(.LINE_BYTES(LINE_BYTES)) u_rsp_mask (
    .new_data (bus_rdata),
    .old_data ({DATA_W{1'b0}}),
    .byte_sel (be_q),
    .merged   (masked_line)
  );

  // next-state logic
  always_comb begin
    accept    = req_valid && (state_q == ST_IDLE);
    full_line = (req_be == ALL_BE);
    rd_done   = (state_q == ST_RD_WAIT) && bus_rvalid;
    state_d   = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_write && !(req_in_mem && !full_line)) state_d = ST_WR_REQ;
          else                                          state_d = ST_RD_REQ;
        end
      end
      ST_RD_REQ:  if (bus_ready) state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (bus_rvalid) state_d = wr_q ? ST_WR_REQ : ST_RESP;
      ST_WR_REQ:  if (bus_ready) state_d = ST_RESP;
      ST_RESP:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // datapath enables and next values
  always_comb begin
    cap_en   = accept;
    wdata_en = accept || (rd_done && wr_q);
    rdata_en = accept || (rd_done && !wr_q);
    wdata_d  = accept ? req_wdata : merged_line;
    rdata_d  = accept ? {DATA_W{1'b0}} : masked_line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      be_q   <= '0;
      wr_q   <= 1'b0;
      mem_q  <= 1'b0;
    end else if (cap_en) begin
      addr_q <= req_addr & ~OFF_MASK;
      be_q   <= req_be;
      wr_q   <= req_write;
      mem_q  <= req_in_mem;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wdata_q <= '0;
    else if (wdata_en) wdata_q <= wdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  // outputs
  always_comb begin
    cmd_e = CMD_COH_RD;
    if (state_q == ST_WR_REQ) cmd_e = mem_q ? CMD_COH_WR : CMD_UC_WR;
    else if (!mem_q)          cmd_e = CMD_UC_RD;
    else if (wr_q)            cmd_e = CMD_COH_RDX;
    else                      cmd_e = CMD_COH_RD;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign bus_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign bus_cmd   = cmd_e;
  assign bus_addr  = addr_q;
  assign bus_be    = mem_q ? ALL_BE : be_q;
  assign bus_wdata = wdata_q;
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_write = wr_q;
  assign rsp_rdata = rdata_q;

  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_cmd) && $stable(bus_addr)
                                    && $stable(bus_be) && $stable(bus_wdata)));

  // R8
  req_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10
  rsp_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !bus_valid);

  // R2
  coh_full_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (bus_cmd == CMD_COH_RD || bus_cmd == CMD_COH_RDX || bus_cmd == CMD_COH_WR))
      |-> (bus_be == ALL_BE));

  // R4
  rmw_write_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_cmd == CMD_COH_RDX) |=> (!bus_valid && !req_ready && !rsp_valid));

endmodule

// File: rtl/dma_coh_conv.sv
module dma_coh_conv #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       cfg_mem_base,
  input  logic [ADDR_W-1:0]       cfg_mem_size,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_write,
  input  logic [LINE_BYTES-1:0]   req_be,
  input  logic [LINE_BYTES*8-1:0] req_wdata,
  output logic                    bus_valid,
  input  logic                    bus_ready,
  output logic [2:0]              bus_cmd,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [LINE_BYTES-1:0]   bus_be,
  output logic [LINE_BYTES*8-1:0] bus_wdata,
  input  logic                    bus_rvalid,
  input  logic [LINE_BYTES*8-1:0] bus_rdata,
  output logic                    rsp_valid,
  output logic                    rsp_write,
  output logic [LINE_BYTES*8-1:0] rsp_rdata
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic                   in_mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  dcc_range_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_range (
    .addr     (req_addr),
    .win_base (cfg_mem_base),
    .win_size (cfg_mem_size),
    .in_mem   (in_mem)
  );

  dcc_ctrl #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .req_be     (req_be),
    .req_wdata  (req_wdata),
    .req_in_mem (in_mem),
    .bus_valid  (bus_valid),
    .bus_ready  (bus_ready),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_write  (rsp_write),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: tb/sim_dma_coh_conv.sv
module sim_dma_coh_conv;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam logic [31:0] SIZE = 32'h0000_4000;
  localparam logic [2:0] C_CRD = 3'd0, C_RDX = 3'd1, C_CWR = 3'd2, C_URD = 3'd3, C_UWR = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_be = '0;
  logic [255:0] req_wdata = '0;
  logic bus_ready = 1'b0, bus_rvalid = 1'b0;
  logic [255:0] bus_rdata = '0;
  logic req_ready, bus_valid, rsp_valid, rsp_write;
  logic [2:0] bus_cmd;
  logic [31:0] bus_addr, bus_be;
  logic [255:0] bus_wdata, rsp_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_coh_conv u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mem_base(BASE), .cfg_mem_size(SIZE),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_rdata(rsp_rdata)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL R8 watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_in_mem(input logic [31:0] a);
    logic [31:0] line = {a[31:5], 5'd0};
    return (line >= BASE) && ((line - BASE) < SIZE);
  endfunction

  function automatic logic [255:0] line_data(input logic [31:0] a);
    logic [255:0] d;
    for (int k = 0; k < 8; k++) d[32*k +: 32] = (a * 32'h9E37_79B1) ^ (32'h0101_0101 * (k + 1));
    return d;
  endfunction

  function automatic logic [255:0] merge_bytes(input logic [255:0] nd, input logic [255:0] od,
                                               input logic [31:0] be);
    logic [255:0] r;
    for (int b = 0; b < 32; b++) r[8*b +: 8] = be[b] ? nd[8*b +: 8] : od[8*b +: 8];
    return r;
  endfunction

  task automatic serve(input logic [2:0] ecmd, input logic [31:0] eaddr, input logic [31:0] ebe,
                       input bit chk_wd, input logic [255:0] ewd, input string tag, input string ctag);
    int n = 0;
    int d;
    while (!bus_valid && n < 50) begin @(negedge clk); n++; end
    chk(bus_valid, tag, "bus_valid", 256'(bus_valid), 256'(1));
    chk(bus_cmd == ecmd, ctag, "bus_cmd", 256'(bus_cmd), 256'(ecmd));
    chk(bus_addr == eaddr, tag, "bus_addr", 256'(bus_addr), 256'(eaddr));
    chk(bus_be == ebe, tag, "bus_be", 256'(bus_be), 256'(ebe));
    if (chk_wd) chk(bus_wdata == ewd, tag, "bus_wdata", bus_wdata, ewd);
    chk(!req_ready, "R8", "req_ready in flight", 256'(req_ready), 256'(0));
    d = $urandom % 3;
    repeat (d) begin
      @(negedge clk);
      chk(bus_valid && bus_cmd == ecmd && bus_addr == eaddr && bus_be == ebe,
          "R9", "held request", {bus_addr, bus_be, 5'd0, bus_cmd}, {eaddr, ebe, 5'd0, ecmd});
    end
    bus_ready = 1'b1;
    @(negedge clk);
    bus_ready = 1'b0;
    if (ecmd == C_CRD || ecmd == C_RDX || ecmd == C_URD) begin
      repeat ($urandom % 3) @(negedge clk);
      bus_rvalid = 1'b1;
      bus_rdata  = line_data(eaddr);
      @(negedge clk);
      bus_rvalid = 1'b0;
      bus_rdata  = '0;
    end
  endtask

  task automatic do_req(input logic [31:0] a, input bit wr, input logic [31:0] be,
                        input logic [255:0] wd, input string ctag);
    logic [31:0] la = {a[31:5], 5'd0};
    bit mem = exp_in_mem(a);
    bit full = (be == 32'hFFFF_FFFF);
    logic [255:0] ld = line_data(la);
    logic [255:0] exp_rsp;
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_be = be; req_wdata = wd;
    while (!req_ready && n < 50) begin @(negedge clk); n++; end
    @(negedge clk);
    req_valid = 1'b0;
    if (mem && !wr) begin
      serve(C_CRD, la, 32'hFFFF_FFFF, 1'b0, '0, "R2", ctag);
      exp_rsp = merge_bytes(ld, '0, be);
    end else if (mem && wr && full) begin
      serve(C_CWR, la, 32'hFFFF_FFFF, 1'b1, wd, "R3", ctag);
      exp_rsp = '0;
    end else if (mem && wr) begin
      serve(C_RDX, la, 32'hFFFF_FFFF, 1'b0, '0, "R4", ctag);
      serve(C_CWR, la, 32'hFFFF_FFFF, 1'b1, merge_bytes(wd, ld, be), "R4", "R4");
      exp_rsp = '0;
    end else if (!wr) begin
      serve(C_URD, la, be, 1'b0, '0, "R5", ctag);
      exp_rsp = merge_bytes(ld, '0, be);
    end else begin
      serve(C_UWR, la, be, 1'b1, wd, "R6", ctag);
      exp_rsp = '0;
    end
    n = 0;
    while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
    chk(rsp_valid, "R10", "rsp_valid", 256'(rsp_valid), 256'(1));
    chk(!bus_valid, "R10", "bus idle at response", 256'(bus_valid), 256'(0));
    chk(rsp_rdata == exp_rsp, "R7", "rsp_rdata", rsp_rdata, exp_rsp);
    chk(rsp_write == wr, "R7", "rsp_write", 256'(rsp_write), 256'(wr));
    @(negedge clk);
    chk(!rsp_valid, "R10", "rsp pulse width", 256'(rsp_valid), 256'(0));
    chk(req_ready, "R8", "req_ready after response", 256'(req_ready), 256'(1));
  endtask

  function automatic logic [255:0] rand_line();
    logic [255:0] d;
    for (int k = 0; k < 8; k++) d[32*k +: 32] = $urandom;
    return d;
  endfunction

  initial begin
    void'($urandom(32'd20231));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(req_ready && !bus_valid && !rsp_valid, "R11", "reset outputs",
        {253'd0, req_ready, bus_valid, rsp_valid}, 256'b100);

    // R1 window edges
    do_req(BASE, 1'b0, 32'h0000_00F0, '0, "R1");
    do_req(BASE + SIZE - 32'd32 + 32'd7, 1'b0, 32'hFFFF_FFFF, '0, "R1");
    do_req(BASE + SIZE, 1'b0, 32'h0000_0003, '0, "R1");
    do_req(BASE - 32'd1, 1'b0, 32'h8000_0001, '0, "R1");
    // R3 full write in memory
    do_req(BASE + 32'h100, 1'b1, 32'hFFFF_FFFF, rand_line(), "R3");
    // R4 partial write in memory, including the last line
    do_req(BASE + 32'h240, 1'b1, 32'h00FF_0F01, rand_line(), "R4");
    do_req(BASE + SIZE - 32'd32, 1'b1, 32'h8000_0000, rand_line(), "R4");
    // R6 partial write outside memory, never read
    do_req(BASE + SIZE, 1'b1, 32'h0000_F00F, rand_line(), "R6");
    do_req(32'h0000_0040, 1'b1, 32'hFFFF_FFFF, rand_line(), "R6");
    // R5 uncached read
    do_req(32'hF000_0020, 1'b0, 32'h0F0F_0F0F, '0, "R5");

    for (int i = 0; i < 120; i++) begin
      logic [31:0] a;
      logic [31:0] be;
      bit wr = $urandom % 2;
      int sel = $urandom % 4;
      if (sel == 0)      a = BASE + ($urandom % SIZE);
      else if (sel == 1) a = BASE + SIZE + ($urandom % 32'h100);
      else if (sel == 2) a = BASE - 32'd1 - ($urandom % 32'h100);
      else               a = $urandom;
      sel = $urandom % 4;
      if (sel == 0)      be = 32'hFFFF_FFFF;
      else if (sel == 1) be = 32'h1 << ($urandom % 32);
      else               be = $urandom;
      do_req(a, wr, be, rand_line(), exp_in_mem(a) ? "R1" : "R1");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule